// File: doc/BRIEF.md
# Warp Divergence Mask Stack

This block keeps the control-flow divergence state of a single warp of SIMT lanes. It holds the warp's active-lane mask and a small stack of reconvergence entries. The execute stage drives it with three commands. A split carries a per-lane branch predicate and the fall-through address. A join marks the reconvergence point. A launch loads a fresh lane mask while no divergence is outstanding.

On a split, the currently active lanes are divided by the predicate. If both groups are non-empty, the block saves the pre-split mask. It also saves the not-taken group together with its fall-through address, and then runs the taken group. If every active lane agrees, the block saves only a marker that restores the same mask at the join, and no lane is redirected. A join pops the top entry. A pending-path entry switches the mask to the waiting lanes and emits a one-cycle fetch redirect. A marker entry only restores the saved mask, and fetch continues sequentially. Divergent loops get no special support.

Any command that would push past the stack depth, and any join on an empty stack, sets a sticky error flag and changes nothing else.

Top module: `warp_diverge_stack`

## Requirements
- R1: While reset is asserted and right after it, active_mask equals 1 (lane 0 only), stack_count is 0, err_flag is 0 and redirect_valid is 0.
- R2: A split whose active lanes contain both predicate-1 and predicate-0 lanes takes effect on the next edge. stack_count rises by 2 and active_mask becomes active_mask AND split_pred.
- R3: A split whose active lanes all carry the same predicate value raises stack_count by 1 and leaves active_mask unchanged. redirect_valid stays 0.
- R4: A join whose top entry was pushed as the not-taken half of a divergent split has this effect one cycle later: active_mask becomes that not-taken lane set, redirect_valid is 1 for exactly that cycle, redirect_pc equals the split's split_fall_pc, and stack_count falls by 1.
- R5: A join whose top entry is a restore marker sets active_mask to the mask that was active before the matching split. It leaves redirect_valid at 0 and lowers stack_count by 1.
- R6: A split that needs more free entries than remain sets err_flag and leaves stack_count and active_mask unchanged. A divergent split needs 2 entries and a unanimous split needs 1. A divergent split with only one free entry pushes nothing.
- R7: A join while stack_count is 0 sets err_flag and leaves active_mask and stack_count unchanged.
- R8: Once set, err_flag stays 1 until reset.
- R9: When split_valid and join_valid are both high in one cycle, only the split acts and the join is ignored.
- R10: Predicate bits of inactive lanes have no effect. They do not change the unanimous/divergent classification or the resulting mask.
- R11: A launch loads launch_mask into active_mask only when stack_count is 0, neither split_valid nor join_valid is high, and launch_mask is non-zero. Otherwise it is ignored, so active_mask is never zero.
- R12: stack_count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_valid | input | 1 | Split command this cycle |
| split_pred | input | LANES | Per-lane branch predicate of the split |
| split_fall_pc | input | PC_W | Fall-through address for the not-taken lanes |
| join_valid | input | 1 | Join (reconvergence) command this cycle |
| launch_valid | input | 1 | Request to load a new active mask |
| launch_mask | input | LANES | Mask to load on launch |
| active_mask | output | LANES | Lanes currently executing |
| redirect_valid | output | 1 | One-cycle fetch redirect after a pending-path join |
| redirect_pc | output | PC_W | Fetch address for the redirect |
| stack_count | output | CNT_W | Number of occupied stack entries |
| err_flag | output | 1 | Sticky overflow/underflow error |

## Verification
The bench builds the block with LANES=8, DEPTH=4 and PC_W=16. Eight lanes make a random predicate often unanimous over the active lanes and often divergent, so both split kinds and both join kinds occur many times. A depth of four is filled by two divergent splits or four unanimous ones. This brings the full-stack, one-free-slot and empty-stack corners within a few commands of reset. The 16-bit address width keeps the redirect values readable while still checking every bit of the address path.

// File: rtl/wds_pkg.sv
package wds_pkg;

   // Kind of a saved reconvergence entry
   typedef enum logic {
      ENT_RESTORE = 1'b0,
      ENT_PENDING = 1'b1
   } ent_kind_e;

   // Command selected for the current cycle (split > join > launch)
   typedef enum logic [1:0] {
      CMD_IDLE   = 2'd0,
      CMD_SPLIT  = 2'd1,
      CMD_JOIN   = 2'd2,
      CMD_LAUNCH = 2'd3
   } cmd_e;

endpackage

// File: rtl/wds_lane_split.sv
module wds_lane_split #(
   parameter int LANES = 32
) (
   input  logic [LANES-1:0] active,
   input  logic [LANES-1:0] pred,
   output logic [LANES-1:0] taken,
   output logic [LANES-1:0] not_taken,
   output logic             diverged
);

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         assign taken[l]     = active[l] &  pred[l];
         assign not_taken[l] = active[l] & ~pred[l];
      end
   endgenerate

   assign diverged = (|taken) & (|not_taken);

endmodule

// File: rtl/wds_ctrl.sv
module wds_ctrl
   import wds_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             split_valid,
   input  logic             join_valid,
   input  logic             launch_valid,
   input  logic             launch_any,
   input  logic             diverged,
   input  logic [CNT_W-1:0] count,
   output cmd_e             cmd,
   output logic             cmd_ok,
   output logic [1:0]       push_n,
   output logic             pop,
   output logic             raise_err
);

   localparam int NEED_DIV = 2;
   localparam int NEED_UNA = 1;

   int free_slots;
   int need;

   always_comb begin
      free_slots = DEPTH - int'(count);
      need       = diverged ? NEED_DIV : NEED_UNA;

      cmd = CMD_IDLE;
      if (split_valid)       cmd = CMD_SPLIT;
      else if (join_valid)   cmd = CMD_JOIN;
      else if (launch_valid) cmd = CMD_LAUNCH;

      cmd_ok    = 1'b0;
      push_n    = 2'd0;
      pop       = 1'b0;
      raise_err = 1'b0;
      unique case (cmd)
         CMD_SPLIT: begin
            if (need <= free_slots) begin
               cmd_ok = 1'b1;
               push_n = diverged ? 2'd2 : 2'd1;
            end else begin
               raise_err = 1'b1;
            end
         end
         CMD_JOIN: begin
            if (count != '0) begin
               cmd_ok = 1'b1;
               pop    = 1'b1;
            end else begin
               raise_err = 1'b1;
            end
         end
         CMD_LAUNCH: begin
            cmd_ok = (count == '0) && launch_any;
         end
         default: begin
            cmd_ok = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/wds_stack.sv
module wds_stack
   import wds_pkg::*;
#(
   parameter int LANES = 32,
   parameter int PC_W  = 32,
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       push_n,
   input  logic             pop,
   input  logic [LANES-1:0] lo_mask,
   input  logic [LANES-1:0] hi_mask,
   input  logic [PC_W-1:0]  hi_pc,
   output logic [LANES-1:0] top_mask,
   output logic [PC_W-1:0]  top_pc,
   output ent_kind_e        top_kind,
   output logic [CNT_W-1:0] count
);

   localparam int EXT_W = CNT_W + 1;

   logic [LANES-1:0] ent_mask [DEPTH];
   logic [PC_W-1:0]  ent_pc   [DEPTH];
   ent_kind_e        ent_kind [DEPTH];

   logic [EXT_W-1:0] count_ext;
   assign count_ext = EXT_W'(count);

   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_ent
         logic [LANES-1:0] r_mask;
         logic [PC_W-1:0]  r_pc;
         ent_kind_e        r_kind;
         logic             we_lo;
         logic             we_hi;

         assign we_lo = (push_n != 2'd0) && (count_ext == EXT_W'(i));
         assign we_hi = (push_n == 2'd2) && ((count_ext + EXT_W'(1)) == EXT_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_mask <= '0;
               r_pc   <= '0;
               r_kind <= ENT_RESTORE;
            end else if (we_hi) begin
               r_mask <= hi_mask;
               r_pc   <= hi_pc;
               r_kind <= ENT_PENDING;
            end else if (we_lo) begin
               r_mask <= lo_mask;
               r_pc   <= '0;
               r_kind <= ENT_RESTORE;
            end
         end

         assign ent_mask[i] = r_mask;
         assign ent_pc[i]   = r_pc;
         assign ent_kind[i] = r_kind;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + CNT_W'(push_n) - CNT_W'(pop);
   end

   always_comb begin
      top_mask = '0;
      top_pc   = '0;
      top_kind = ENT_RESTORE;
      for (int k = 0; k < DEPTH; k++) begin
         if (count_ext == EXT_W'(k + 1)) begin
            top_mask = ent_mask[k];
            top_pc   = ent_pc[k];
            top_kind = ent_kind[k];
         end
      end
   end

endmodule

// File: rtl/warp_diverge_stack.sv
module warp_diverge_stack
   import wds_pkg::*;
#(
   parameter int LANES = 32,
   parameter int PC_W  = 32,
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             split_valid,
   input  logic [LANES-1:0] split_pred,
   input  logic [PC_W-1:0]  split_fall_pc,
   input  logic             join_valid,
   input  logic             launch_valid,
   input  logic [LANES-1:0] launch_mask,
   output logic [LANES-1:0] active_mask,
   output logic             redirect_valid,
   output logic [PC_W-1:0]  redirect_pc,
   output logic [CNT_W-1:0] stack_count,
   output logic             err_flag
);

   localparam logic [LANES-1:0] RESET_MASK = LANES'(1);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("warp_diverge_stack: LANES must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("warp_diverge_stack: DEPTH must be at least 2");
      end
      if (PC_W < 1) begin : g_bad_pc
         $error("warp_diverge_stack: PC_W must be at least 1");
      end
      if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
         $error("warp_diverge_stack: CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic [LANES-1:0] taken;
   logic [LANES-1:0] not_taken;
   logic             diverged;

   wds_lane_split #(.LANES(LANES)) u_split (
      .active    (active_mask),
      .pred      (split_pred),
      .taken     (taken),
      .not_taken (not_taken),
      .diverged  (diverged)
   );

   cmd_e       cmd;
   logic       cmd_ok;
   logic [1:0] push_n;
   logic       pop;
   logic       raise_err;

   wds_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
      .split_valid  (split_valid),
      .join_valid   (join_valid),
      .launch_valid (launch_valid),
      .launch_any   (|launch_mask),
      .diverged     (diverged),
      .count        (stack_count),
      .cmd          (cmd),
      .cmd_ok       (cmd_ok),
      .push_n       (push_n),
      .pop          (pop),
      .raise_err    (raise_err)
   );

   logic [LANES-1:0] top_mask;
   logic [PC_W-1:0]  top_pc;
   ent_kind_e        top_kind;

   wds_stack #(
      .LANES (LANES),
      .PC_W  (PC_W),
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_n   (push_n),
      .pop      (pop),
      .lo_mask  (active_mask),
      .hi_mask  (not_taken),
      .hi_pc    (split_fall_pc),
      .top_mask (top_mask),
      .top_pc   (top_pc),
      .top_kind (top_kind),
      .count    (stack_count)
   );

   logic [LANES-1:0] mask_nxt;
   logic             redir_nxt;
   logic [PC_W-1:0]  rpc_nxt;

   always_comb begin
      mask_nxt  = active_mask;
      redir_nxt = 1'b0;
      rpc_nxt   = redirect_pc;
      if (cmd_ok) begin
         unique case (cmd)
            CMD_SPLIT: begin
               if (diverged) mask_nxt = taken;
            end
            CMD_JOIN: begin
               mask_nxt = top_mask;
               if (top_kind == ENT_PENDING) begin
                  redir_nxt = 1'b1;
                  rpc_nxt   = top_pc;
               end
            end
            CMD_LAUNCH: begin
               mask_nxt = launch_mask;
            end
            default: begin
               mask_nxt = active_mask;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_mask    <= RESET_MASK;
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
         err_flag       <= 1'b0;
      end else begin
         active_mask    <= mask_nxt;
         redirect_valid <= redir_nxt;
         redirect_pc    <= rpc_nxt;
         err_flag       <= err_flag | raise_err;
      end
   end

endmodule

// File: rtl/wds_checker.sv
module wds_checker #(
   parameter int LANES = 32,
   parameter int PC_W  = 32,
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             split_valid,
   input logic             join_valid,
   input logic [LANES-1:0] active_mask,
   input logic             redirect_valid,
   input logic [PC_W-1:0]  redirect_pc,
   input logic [CNT_W-1:0] stack_count,
   input logic             err_flag
);

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || (active_mask == LANES'(1) && stack_count == '0 &&
                             !err_flag && !redirect_valid))); // R1

   AST_SPLIT_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
      split_valid |=> ((active_mask & ~$past(active_mask)) == '0)); // R2

   AST_REDIRECT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> ($past(join_valid) && !$past(split_valid))); // R4

   AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> (!redirect_valid || $past(join_valid)) && ($stable(redirect_pc) || redirect_valid)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (split_valid && stack_count == CNT_W'(DEPTH)) |=> (err_flag && $stable(stack_count) && $stable(active_mask))); // R6

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (join_valid && !split_valid && stack_count == '0) |=> (err_flag && $stable(active_mask) && stack_count == '0)); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag); // R8

   AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      active_mask != '0); // R11

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      stack_count <= CNT_W'(DEPTH)); // R12

endmodule

bind warp_diverge_stack wds_checker #(
   .LANES (LANES),
   .PC_W  (PC_W),
   .DEPTH (DEPTH),
   .CNT_W (CNT_W)
) u_wds_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .split_valid    (split_valid),
   .join_valid     (join_valid),
   .active_mask    (active_mask),
   .redirect_valid (redirect_valid),
   .redirect_pc    (redirect_pc),
   .stack_count    (stack_count),
   .err_flag       (err_flag)
);

// File: tb/warp_diverge_stack_test.sv
module warp_diverge_stack_test;

   localparam int LANES = 8;
   localparam int PC_W  = 16;
   localparam int DEPTH = 4;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             split_valid = 1'b0;
   logic [LANES-1:0] split_pred = '0;
   logic [PC_W-1:0]  split_fall_pc = '0;
   logic             join_valid = 1'b0;
   logic             launch_valid = 1'b0;
   logic [LANES-1:0] launch_mask = '0;
   logic [LANES-1:0] active_mask;
   logic             redirect_valid;
   logic [PC_W-1:0]  redirect_pc;
   logic [CNT_W-1:0] stack_count;
   logic             err_flag;

   warp_diverge_stack #(
      .LANES (LANES), .PC_W (PC_W), .DEPTH (DEPTH), .CNT_W (CNT_W)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .split_valid (split_valid), .split_pred (split_pred), .split_fall_pc (split_fall_pc),
      .join_valid (join_valid), .launch_valid (launch_valid), .launch_mask (launch_mask),
      .active_mask (active_mask), .redirect_valid (redirect_valid), .redirect_pc (redirect_pc),
      .stack_count (stack_count), .err_flag (err_flag)
   );

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   logic [LANES-1:0] m_mask;
   int               m_cnt;
   logic             m_err;
   logic             m_rv;
   logic [PC_W-1:0]  m_rpc;
   logic [LANES-1:0] m_smask [DEPTH];
   logic [PC_W-1:0]  m_spc   [DEPTH];
   logic             m_spend [DEPTH];

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      check(tag, "active_mask", 32'(active_mask), 32'(m_mask));
      check(tag, "stack_count", 32'(stack_count), 32'(m_cnt));
      check(tag, "err_flag", 32'(err_flag), 32'(m_err));
      check(tag, "redirect_valid", 32'(redirect_valid), 32'(m_rv));
      if (m_rv) check(tag, "redirect_pc", 32'(redirect_pc), 32'(m_rpc));
   endtask

   function automatic logic is_divergent(input logic [LANES-1:0] m, input logic [LANES-1:0] p);
      return ((m & p) != '0) && ((m & ~p) != '0);
   endfunction

   task automatic model_reset();
      m_mask = LANES'(1);
      m_cnt  = 0;
      m_err  = 1'b0;
      m_rv   = 1'b0;
      m_rpc  = '0;
   endtask

   task automatic model_apply();
      logic [LANES-1:0] t;
      logic [LANES-1:0] f;
      int need;
      m_rv = 1'b0;
      if (split_valid) begin
         t = m_mask & split_pred;
         f = m_mask & ~split_pred;
         need = is_divergent(m_mask, split_pred) ? 2 : 1;
         if (m_cnt + need > DEPTH) m_err = 1'b1;
         else begin
            m_smask[m_cnt] = m_mask; m_spend[m_cnt] = 1'b0; m_cnt++;
            if (need == 2) begin
               m_smask[m_cnt] = f; m_spc[m_cnt] = split_fall_pc; m_spend[m_cnt] = 1'b1; m_cnt++;
               m_mask = t;
            end
         end
      end else if (join_valid) begin
         if (m_cnt == 0) m_err = 1'b1;
         else begin
            m_cnt--;
            m_mask = m_smask[m_cnt];
            if (m_spend[m_cnt]) begin m_rv = 1'b1; m_rpc = m_spc[m_cnt]; end
         end
      end else if (launch_valid && m_cnt == 0 && launch_mask != '0) begin
         m_mask = launch_mask;
      end
   endtask

   task automatic idle_inputs();
      split_valid = 1'b0; join_valid = 1'b0; launch_valid = 1'b0;
   endtask

   // inputs are set at a negedge; one edge later the outputs are compared
   task automatic cycle(input string tag);
      model_apply();
      @(negedge clk);
      check_all(tag);
      idle_inputs();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle_inputs();
      @(negedge clk);
      model_reset();
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");
   endtask

   task automatic op_split(input logic [LANES-1:0] p, input logic [PC_W-1:0] pc, input string tag);
      split_valid = 1'b1; split_pred = p; split_fall_pc = pc; cycle(tag);
   endtask
   task automatic op_join(input string tag);
      join_valid = 1'b1; cycle(tag);
   endtask
   task automatic op_launch(input logic [LANES-1:0] m, input string tag);
      launch_valid = 1'b1; launch_mask = m; cycle(tag);
   endtask

   logic finished = 1'b0;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_2024));
      model_reset();
      @(negedge clk);
      do_reset();

      // ---- directed corner cases ----
      op_launch(8'hFF, "R11");
      op_split(8'h0F, 16'h0100, "R2");
      check("R2", "taken mask", 32'(active_mask), 32'h0F);
      op_join("R4");
      check("R4", "pending mask", 32'(active_mask), 32'hF0);
      check("R4", "redirect_pc", 32'(redirect_pc), 32'h0100);
      @(negedge clk);
      check("R4", "redirect one cycle", 32'(redirect_valid), 32'h0);
      op_join("R5");
      check("R5", "restored mask", 32'(active_mask), 32'hFF);
      check("R5", "no redirect", 32'(redirect_valid), 32'h0);

      // unanimous and inactive-lane predicates
      op_launch(8'h0F, "R11");
      op_split(8'hFF, 16'h0200, "R3");
      check("R3", "mask kept", 32'(active_mask), 32'h0F);
      op_split(8'h3F, 16'h0300, "R10");
      check("R10", "count after unanimous", 32'(stack_count), 32'h2);
      op_launch(8'h33, "R11");
      check("R11", "launch ignored when stack busy", 32'(active_mask), 32'h0F);
      op_split(8'hF3, 16'h0400, "R10");
      check("R10", "inactive bits ignored", 32'(active_mask), 32'h03);
      // stack now full (4): unanimous split overflows
      op_split(8'h00, 16'h0500, "R6");
      check("R6", "overflow error", 32'(err_flag), 32'h1);
      check("R6", "count kept", 32'(stack_count), 32'h4);

      // divergent split with one free slot
      do_reset();
      op_launch(8'hFF, "R11");
      op_split(8'hFF, 16'h0010, "R3");
      op_split(8'hFF, 16'h0011, "R3");
      op_split(8'hFF, 16'h0012, "R3");
      op_split(8'h01, 16'h0013, "R6");
      check("R6", "partial push refused", 32'(stack_count), 32'h3);
      check("R6", "mask kept on refusal", 32'(active_mask), 32'hFF);

      // underflow and stickiness
      do_reset();
      op_join("R7");
      check("R7", "underflow error", 32'(err_flag), 32'h1);
      op_launch(8'h00, "R11");
      check("R11", "zero launch ignored", 32'(active_mask), 32'h01);
      op_launch(8'hAA, "R8");
      check("R8", "err still set", 32'(err_flag), 32'h1);

      // split and join together
      do_reset();
      op_launch(8'hFF, "R11");
      split_valid = 1'b1; split_pred = 8'hC0; split_fall_pc = 16'h0777; join_valid = 1'b1;
      cycle("R9");
      check("R9", "split won", 32'(stack_count), 32'h2);
      check("R9", "no redirect", 32'(redirect_valid), 32'h0);

      // ---- constrained random ----
      for (int it = 0; it < 4000; it++) begin
         int r;
         if (it % 160 == 0) do_reset();
         r = int'($urandom_range(99));
         if (r < 8) begin
            op_launch(LANES'($urandom), "R11");
         end else if (r < 45) begin
            logic [LANES-1:0] p;
            p = LANES'($urandom);
            if ($urandom_range(3) == 0) p = ($urandom_range(1) == 0) ? '0 : '1;
            op_split(p, PC_W'($urandom), is_divergent(m_mask, p) ? "R2" : "R3");
         end else if (r < 85) begin
            op_join("R4");
         end else if (r < 90) begin
            split_valid = 1'b1; split_pred = LANES'($urandom);
            split_fall_pc = PC_W'($urandom); join_valid = 1'b1;
            cycle("R9");
         end else begin
            cycle("R12");
         end
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule